// File: doc/BRIEF.md
# Interrupt Source Enable and Status Register

This block collects up to eight interrupt sources behind one register. The same register slot works in two directions. A write loads the enable mask. A read returns the pending flags of the enabled sources. Each source input is an asynchronous level. It passes through a synchronizer, and a rising edge sets a sticky pending flag, but only while that source is enabled. A single level interrupt output stays high while any readable pending flag is set.

Software clears a source by writing its enable bit to zero, which drops the flag. Writing the bit back to one re-arms the source. A handler can therefore read the status, disable the sources it finds, and read again until the status is zero, catching every edge that arrived in between. A fixed mask parameter hides the positions that have no source behind them. Those bits always read as zero and never raise the interrupt.

Top module: `irq_enable_status`

## Requirements
- R1: After reset the enable mask is all zeros, the status reads 0 and the interrupt output is low.
- R2: A write loads the enable mask. Only sources whose enable bit is 1 can set their pending flag.
- R3: A rising edge on a source input applied before clock edge k appears in the status after edge k+2 and not earlier (two synchronizer flops plus the flag register).
- R4: Only a low-to-high transition sets a flag. An input held high does not set a flag again after the flag is cleared and re-armed, and a falling edge sets nothing.
- R5: A rising edge that arrives while a source is disabled is discarded. It is not reported after the source is enabled later.
- R6: The status equals the pending flags ANDed with the valid mask (default 0x3F). Bits 6 and 7 read 0 whatever their inputs do.
- R7: The interrupt output is high exactly when the status is non-zero. Without a write it stays high once it is high.
- R8: Writing 0 to an enable bit clears that source's flag at the write's clock edge. Flags whose enable bit stays 1 are kept.
- R9: A rising edge on a source that stays enabled, arriving in the same cycle as a write that clears another source, is recorded and appears in the status.
- R10: Writing 0x00 disables every source, clears every flag and drops the interrupt output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Asynchronous interrupt source levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | NUM_SRC | New enable mask |
| rd_data_o | output | NUM_SRC | Masked pending status |
| irq_o | output | 1 | Level interrupt request |

## Verification
The embedded assertions check several properties on every cycle. The synchronizer output trails its first stage by exactly one clock. No flag appears without a detected rising edge. A disabling write leaves no flag set behind it. The interrupt holds steady between writes and falls after an all-zero write. Other behaviour can only be shown by the bench's scenarios. These are the three-cycle latency from input to status, the loss of edges seen while a source is disabled, the hiding of unimplemented bits, and the capture of an edge that lands in the same cycle as a clearing write. A random mix of writes and toggling inputs is compared each cycle against a bench model.

// File: rtl/irq_es_pkg.sv
package irq_es_pkg;
    localparam int unsigned IRQ_DEF_SOURCES = 8;
    localparam int unsigned IRQ_DEF_SYNC    = 2;
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
                always_comb stage_d[k] = async_i;
            end else begin : g_next
                always_comb stage_d[k] = stage_q[k-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[k] <= '0;
                else        stage_q[k] <= stage_d[k];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

    generate
        if (STAGES >= 2) begin : g_chk
            // R3: final stage trails the previous stage by one clock
            assert_sync_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (sync_o == $past(stage_q[STAGES-2])));
        end
    endgenerate
endmodule

// File: rtl/irq_rise_detect.sv
module irq_rise_detect #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
        rise_o = level_i & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irq_pending_core.sv
module irq_pending_core #(
    parameter int unsigned         NUM_SRC    = 8,
    parameter logic [NUM_SRC-1:0]  VALID_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] rise_i,
    input  logic               wr_en_i,
    input  logic [NUM_SRC-1:0] wr_data_i,
    output logic [NUM_SRC-1:0] status_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] pend;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) st_d.en = wr_data_i;
        // flags survive only where the (possibly new) enable is set;
        // fresh edges are taken on the same terms
        st_d.pend = (st_q.pend | rise_i) & st_d.en & VALID_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.pend & VALID_MASK;

    // R4: a newly set flag needs a detected rising edge in the cycle before
    assert_flag_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.pend & ~$past(st_q.pend) & ~$past(rise_i)) == '0));

    // R8: a disabling write leaves no flag behind in the written-zero positions
    assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> ((st_q.pend & ~$past(wr_data_i)) == '0));
endmodule

// File: rtl/irq_enable_status.sv
module irq_enable_status
    import irq_es_pkg::*;
#(
    parameter int unsigned        NUM_SRC    = IRQ_DEF_SOURCES,
    parameter int unsigned        SYNC_DEPTH = IRQ_DEF_SYNC,
    parameter logic [NUM_SRC-1:0] VALID_MASK = 8'h3F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en_i,
    input  logic [NUM_SRC-1:0] wr_data_i,
    output logic [NUM_SRC-1:0] rd_data_o,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] src_rise;
    logic [NUM_SRC-1:0] status;

    irq_src_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (src_sync)
    );

    irq_rise_detect #(.WIDTH(NUM_SRC)) u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (src_sync),
        .rise_o  (src_rise)
    );

    irq_pending_core #(.NUM_SRC(NUM_SRC), .VALID_MASK(VALID_MASK)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (src_rise),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .status_o  (status)
    );

    assign rd_data_o = status;
    assign irq_o     = |status;

    // R7: without a write the request cannot fall
    assert_irq_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && irq_o) |=> irq_o);

    // R10: an all-zero write drops the request
    assert_zero_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_data_i == '0)) |=> !irq_o);

    // R6: hidden positions never read as set
    assert_hidden_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o & ~VALID_MASK) == '0);
endmodule

// File: tb/test_irq_enable_status.sv
module test_irq_enable_status;
    localparam logic [7:0] VMASK = 8'h3F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    irq_enable_status i_irq_enable_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    // bench model built from the requirements: 3-cycle input latency,
    // rising-edge capture gated by the post-write enable, masked status
    logic [7:0] m_a, m_b, m_c, m_en, m_pend;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_a <= '0; m_b <= '0; m_c <= '0; m_en <= '0; m_pend <= '0;
        end else begin
            m_a <= src; m_b <= m_a; m_c <= m_b;
            m_en <= wr_en ? wr_data : m_en;
            m_pend <= (m_pend | (m_b & ~m_c)) & (wr_en ? wr_data : m_en) & VMASK;
        end
    end

    function automatic logic [7:0] exp_status();
        return m_pend & VMASK;
    endfunction

    task automatic chk(input string req, input logic [7:0] e_rd, input logic e_irq);
        n_vec++;
        if (rd_data !== e_rd || irq !== e_irq) begin
            n_bad++;
            $display("FAIL %s: rd=%02h irq=%b expected rd=%02h irq=%b", req, rd_data, irq, e_rd, e_irq);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        cyc(1);
        wr_en = 1'b0;
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd4711);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1);
        chk("R1", 8'h00, 1'b0);

        wr(8'hFF);
        src[0] = 1'b1;
        cyc(2);
        chk("R3 early", 8'h00, 1'b0);
        cyc(1);
        chk("R3", 8'h01, 1'b1);

        src[7] = 1'b1;
        cyc(4);
        chk("R6", 8'h01, 1'b1);
        cyc(4);
        chk("R7", 8'h01, 1'b1);

        wr(8'hFE);
        chk("R8", 8'h00, 1'b0);
        wr(8'hFF);
        chk("R4 rearm", 8'h00, 1'b0);
        cyc(4);
        chk("R4 held", 8'h00, 1'b0);

        src[0] = 1'b0; cyc(4);
        chk("R4 fall", 8'h00, 1'b0);
        src[0] = 1'b1; cyc(4);
        chk("R3 again", 8'h01, 1'b1);

        // R9: edge on source 1 seen in the same cycle as the write clearing source 0
        src[1] = 1'b1;
        cyc(2);
        wr_en = 1'b1; wr_data = 8'hFE;
        cyc(1);
        wr_en = 1'b0;
        chk("R9", 8'h02, 1'b1);

        wr(8'h00);
        chk("R10", 8'h00, 1'b0);
        src[2] = 1'b1; cyc(4);
        wr(8'hFF); cyc(2);
        chk("R5", 8'h00, 1'b0);

        wr(8'h08);
        src[3] = 1'b1; src[4] = 1'b1;
        cyc(4);
        chk("R2", 8'h08, 1'b1);
        chk("R2 model", exp_status(), |exp_status());

        for (int i = 0; i < 600; i++) begin
            logic [7:0] flip;
            flip = 8'($urandom) & 8'($urandom) & 8'($urandom);
            src = src ^ flip;
            if (($urandom % 6) == 0) begin
                wr_en = 1'b1;
                wr_data = (($urandom % 5) == 0) ? 8'h00 : 8'($urandom);
            end else begin
                wr_en = 1'b0;
            end
            cyc(1);
            chk((wr_en && wr_data == 8'h00) ? "R10 rand" : "R8 rand", exp_status(), |exp_status());
        end
        wr_en = 1'b0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: rd=%02h irq=%b expected run completion", rd_data, irq);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule